// File: doc/BRIEF.md
# Pipelined Booth Carry-Save Multiplier

This block is the multiply core of a fused multiply-add datapath. It takes two 53-bit unsigned significands and recodes the second one (the multiplier) into radix-4 signed digits. It forms one partial-product row per digit and reduces the rows with layers of 3:2 and 4:2 carry-save compressors. The reduction is cut into three register stages. In the last stage, the two remaining product rows are combined with an externally aligned addend vector. The result leaves the block as a redundant pair of vectors (sum and carry). The downstream carry-propagate adder turns that pair into a single number.

A new operand pair may enter on every clock. A result appears three clock edges after its operands were captured. The addend is not stored with its operands. It is sampled from the `addend` port two edges after the operands, in the cycle when the third stage works on that product. This matches an alignment shifter that runs in parallel with the first two stages. A valid flag travels with each operation through all three stages.

Top module: `fmul_booth_csa`

## Requirements
- R1: For every valid operation, (out_sum + out_carry) mod 2^108 equals op_a * op_b + addend mod 2^108. Here op_a and op_b are the 53-bit operands captured together, and addend is the 108-bit value present two edges later.
- R2: An operation captured at rising edge k (in_valid high) makes out_valid high in the cycle that follows edge k+2. out_valid is low in every cycle whose corresponding capture edge had in_valid low.
- R3: Operations issued on consecutive edges produce results on consecutive cycles, in issue order, each one correct.
- R4: The addend is sampled at edge k+2 for the operation captured at edge k. addend values on other edges have no effect on that operation's result.
- R5: A synchronous reset (rst high at a rising edge) clears all stage valid flags. out_valid stays low after reset until a new operation has passed through all three stages. Operations in flight at reset produce no result.
- R6: While out_valid is low, out_sum and out_carry keep their previous values, whatever is driven on op_a, op_b and addend.
- R7: Multiplier patterns that yield negative Booth digits (-1 and -2), including all-ones operands with an all-ones addend, give correct results modulo 2^108.
- R8: A zero operand on either side gives (out_sum + out_carry) mod 2^108 equal to the addend.
- R9: Single-bit operands at every bit position from 0 to 52 give the exact power-of-two product plus the addend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; clears the valid pipeline |
| in_valid | input | 1 | Operand pair on op_a/op_b is to be captured at this edge |
| op_a | input | 53 | Multiplicand significand, unsigned |
| op_b | input | 53 | Multiplier significand, unsigned; Booth-recoded |
| addend | input | 108 | Aligned addend at product weights, sampled two edges after its operands |
| out_valid | output | 1 | out_sum/out_carry hold a new result |
| out_sum | output | 108 | Carry-save sum vector |
| out_carry | output | 108 | Carry-save carry vector |

## Verification
Two things can happen in the same cycle: a new operand pair goes through Booth selection and the first compressor layers, and an older product, issued two cycles earlier, is merged with its addend. The bench issues long back-to-back streams with a fresh random addend for every operation. It drives unrelated random values on the addend port whenever no merge is due. Each result is judged by adding out_sum and out_carry modulo 2^108 and comparing with the product plus the addend that belongs to it. A mixed-up addend timing or pipeline order therefore shows up as a wrong value, not merely as a late one.

// File: rtl/fmul_booth_pkg.sv
package fmul_booth_pkg;

   // number of radix-4 digits needed for an unsigned operand of op_w bits
   function automatic int booth_rows(input int op_w);
      return op_w / 2 + 1;
   endfunction

   // rows remaining after one layer of 3:2 compressors
   function automatic int after_32(input int n);
      return 2 * (n / 3) + n % 3;
   endfunction

   // rows remaining after one layer of 4:2 compressors
   function automatic int after_42(input int n);
      return 2 * (n / 4) + n % 4;
   endfunction

endpackage

// File: rtl/booth_pp_gen.sv
module booth_pp_gen #(
   parameter int OP_W  = 53,
   parameter int W     = 2 * OP_W + 2,
   parameter int NROWS = OP_W / 2 + 1
) (
   input  logic [OP_W-1:0] mcand,
   input  logic [OP_W-1:0] mplier,
   output logic [W-1:0]    rows [NROWS]
);
   localparam int BX_W = 2 * NROWS + 1;

   generate
      if (BX_W < OP_W + 1) begin : g_bad_rows
         $error("booth_pp_gen: NROWS too small for OP_W");
      end
   endgenerate

   // multiplier with an implicit zero below bit 0 and zero extension on top
   logic [BX_W-1:0]  bx;
   logic [W-1:0]     shifted [NROWS];
   logic [NROWS-1:0] negs;

   assign bx = BX_W'({mplier, 1'b0});

   generate
      for (genvar j = 0; j < NROWS; j++) begin : g_digit
         logic [2:0]  trip;
         logic        d_one;
         logic        d_two;
         logic [OP_W:0] mag;
         logic [W-1:0]  base;

         assign trip  = bx[2*j+2 -: 3];
         assign d_one = trip[0] ^ trip[1];
         assign d_two = (trip == 3'b011) | (trip == 3'b100);
         assign negs[j] = trip[2] & ~(trip[1] & trip[0]);
         assign mag  = d_one ? {1'b0, mcand} : (d_two ? {mcand, 1'b0} : '0);
         // negative digit: one's complement now, +1 at weight 4^j added below
         assign base = negs[j] ? ~W'(mag) : W'(mag);
         assign shifted[j] = base << (2 * j);

         if (j == 0) begin : g_first
            assign rows[j] = shifted[j];
         end else begin : g_rest
            // hot-one of the previous row sits in the two free low bits
            assign rows[j] = shifted[j] | (W'(negs[j-1]) << (2 * (j - 1)));
         end
      end
   endgenerate

endmodule

// File: rtl/csa32_level.sv
module csa32_level #(
   parameter int W  = 108,
   parameter int NI = 3,
   parameter int NO = 2
) (
   input  logic [W-1:0] din  [NI],
   output logic [W-1:0] dout [NO]
);
   localparam int NG = NI / 3;
   localparam int NR = NI % 3;

   generate
      if (NO != 2 * NG + NR) begin : g_bad_count
         $error("csa32_level: NO does not match NI");
      end

      for (genvar g = 0; g < NG; g++) begin : g_grp
         logic [W-1:0] x, y, z, maj;
         assign x   = din[3*g];
         assign y   = din[3*g+1];
         assign z   = din[3*g+2];
         assign maj = (x & y) | (x & z) | (y & z);
         assign dout[2*g]   = x ^ y ^ z;
         assign dout[2*g+1] = {maj[W-2:0], 1'b0};
      end

      for (genvar r = 0; r < NR; r++) begin : g_pass
         assign dout[2*NG+r] = din[3*NG+r];
      end
   endgenerate

endmodule

// File: rtl/cmp42_level.sv
module cmp42_level #(
   parameter int W  = 108,
   parameter int NI = 4,
   parameter int NO = 2
) (
   input  logic [W-1:0] din  [NI],
   output logic [W-1:0] dout [NO]
);
   localparam int NG = NI / 4;
   localparam int NR = NI % 4;

   generate
      if (NO != 2 * NG + NR) begin : g_bad_count
         $error("cmp42_level: NO does not match NI");
      end

      for (genvar g = 0; g < NG; g++) begin : g_grp
         logic [W-1:0] w0, w1, w2, w3;
         logic [W-1:0] t_s, t_m, t_c, f_m;
         assign w0 = din[4*g];
         assign w1 = din[4*g+1];
         assign w2 = din[4*g+2];
         assign w3 = din[4*g+3];
         // lateral carry t_c depends only on w0..w2, so no ripple across bits
         assign t_s = w0 ^ w1 ^ w2;
         assign t_m = (w0 & w1) | (w0 & w2) | (w1 & w2);
         assign t_c = {t_m[W-2:0], 1'b0};
         assign f_m = (t_s & w3) | (t_s & t_c) | (w3 & t_c);
         assign dout[2*g]   = t_s ^ w3 ^ t_c;
         assign dout[2*g+1] = {f_m[W-2:0], 1'b0};
      end

      for (genvar r = 0; r < NR; r++) begin : g_pass
         assign dout[2*NG+r] = din[4*NG+r];
      end
   endgenerate

endmodule

// File: rtl/fmul_booth_csa.sv
module fmul_booth_csa
   import fmul_booth_pkg::*;
#(
   parameter int OP_W = 53
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [OP_W-1:0]     op_a,
   input  logic [OP_W-1:0]     op_b,
   input  logic [2*OP_W+1:0]   addend,
   output logic                out_valid,
   output logic [2*OP_W+1:0]   out_sum,
   output logic [2*OP_W+1:0]   out_carry
);
   localparam int W     = 2 * OP_W + 2;
   localparam int NROWS = booth_rows(OP_W);
   localparam int N1A   = after_32(NROWS);
   localparam int N1    = after_32(N1A);   // registered after stage 1
   localparam int N2A   = after_42(N1);
   localparam int N2    = after_32(N2A);   // registered after stage 2
   localparam int N3    = after_42(N2);    // product rows before addend merge

   generate
      if (OP_W < 4) begin : g_bad_width
         $error("fmul_booth_csa: OP_W must be at least 4");
      end
      if (N3 != 2) begin : g_bad_tree
         $error("fmul_booth_csa: tree does not end in two rows for this OP_W");
      end
   endgenerate

   // ---------------- stage 1: recode, select, two 3:2 layers (R1, R7)
   logic [W-1:0] pp   [NROWS];
   logic [W-1:0] l1a  [N1A];
   logic [W-1:0] l1   [N1];
   logic [W-1:0] s1_q [N1];

   booth_pp_gen #(.OP_W(OP_W), .W(W), .NROWS(NROWS)) i_pp (
      .mcand (op_a),
      .mplier(op_b),
      .rows  (pp)
   );

   csa32_level #(.W(W), .NI(NROWS), .NO(N1A)) i_s1_c0 (.din(pp),  .dout(l1a));
   csa32_level #(.W(W), .NI(N1A),   .NO(N1))  i_s1_c1 (.din(l1a), .dout(l1));

   // ---------------- stage 2: 4:2 layer then 3:2 layer
   logic [W-1:0] l2a  [N2A];
   logic [W-1:0] l2   [N2];
   logic [W-1:0] s2_q [N2];

   cmp42_level #(.W(W), .NI(N1),  .NO(N2A)) i_s2_c0 (.din(s1_q), .dout(l2a));
   csa32_level #(.W(W), .NI(N2A), .NO(N2))  i_s2_c1 (.din(l2a),  .dout(l2));

   // ---------------- stage 3: 4:2 layer then 3:2 merge with addend (R4)
   logic [W-1:0] l3   [N3];
   logic [W-1:0] mrg  [3];
   logic [W-1:0] fin  [2];

   cmp42_level #(.W(W), .NI(N2), .NO(N3)) i_s3_c0 (.din(s2_q), .dout(l3));

   assign mrg[0] = l3[0];
   assign mrg[1] = l3[1];
   assign mrg[2] = addend;

   csa32_level #(.W(W), .NI(3), .NO(2)) i_s3_mrg (.din(mrg), .dout(fin));

   // ---------------- valid pipeline (R2, R5)
   logic v1_q, v2_q, v3_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         v1_q <= 1'b0;
         v2_q <= 1'b0;
         v3_q <= 1'b0;
      end else begin
         v1_q <= in_valid;
         v2_q <= v1_q;
         v3_q <= v2_q;
      end
   end

   // ---------------- data registers, loaded only under their valid (R6)
   always_ff @(posedge clk) begin
      if (in_valid) s1_q <= l1;
      if (v1_q)     s2_q <= l2;
      if (v2_q) begin
         out_sum   <= fin[0];
         out_carry <= fin[1];
      end
   end

   assign out_valid = v3_q;

endmodule

// File: rtl/fmul_booth_csa_chk.sv
module fmul_booth_csa_chk #(
   parameter int W = 108
) (
   input logic         clk,
   input logic         rst,
   input logic         in_valid,
   input logic         out_valid,
   input logic [W-1:0] out_sum,
   input logic [W-1:0] out_carry
);
   // non-reset edges seen since the last reset, saturating at 3
   logic [1:0] since_rst;

   always_ff @(posedge clk) begin
      if (rst)                    since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R5: a reset edge leaves no valid result behind
   a_r5_reset_clears: assert property (@(posedge clk)
      rst |=> !out_valid);

   // R5: nothing can emerge before a full pass after reset
   a_r5_no_early: assert property (@(posedge clk) disable iff (rst)
      (since_rst != 2'd3) |-> !out_valid);

   // R2: result valid exactly three edges after capture
   a_r2_latency: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

   // R6: outputs frozen while no new result is presented
   a_r6_hold: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd3 && !out_valid) |-> ($stable(out_sum) && $stable(out_carry)));

endmodule

bind fmul_booth_csa fmul_booth_csa_chk #(.W(2 * OP_W + 2)) i_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .out_valid(out_valid),
   .out_sum  (out_sum),
   .out_carry(out_carry)
);

// File: tb/test_fmul_booth_csa.sv
`timescale 1ns/1ps
module test_fmul_booth_csa;
   localparam int OP_W = 53;
   localparam int W    = 2 * OP_W + 2;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            in_valid = 1'b0;
   logic [OP_W-1:0] op_a = '0;
   logic [OP_W-1:0] op_b = '0;
   logic [W-1:0]    addend = '0;
   logic            out_valid;
   logic [W-1:0]    out_sum;
   logic [W-1:0]    out_carry;

   fmul_booth_csa #(.OP_W(OP_W)) i_fmul_booth_csa (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .op_a     (op_a),
      .op_b     (op_b),
      .addend   (addend),
      .out_valid(out_valid),
      .out_sum  (out_sum),
      .out_carry(out_carry)
   );

   always #2.5 clk = ~clk;   // 200 MHz

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // bench model of the three in-flight slots
   logic         pv [3];
   logic [W-1:0] pe [3];
   logic [W-1:0] pc [3];
   string        pt [3];
   logic [W-1:0] last_s, last_c;
   bit           hold_ok = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [OP_W-1:0] rnd_op();
      return OP_W'({$urandom(), $urandom()});
   endfunction

   function automatic logic [W-1:0] rnd_add();
      return W'({$urandom(), $urandom(), $urandom(), $urandom()});
   endfunction

   task automatic clear_model();
      for (int i = 0; i < 3; i++) begin
         pv[i] = 1'b0; pe[i] = '0; pc[i] = '0; pt[i] = "-";
      end
   endtask

   // one clock: check what is due, then drive the next inputs
   task automatic step(input logic v, input logic [OP_W-1:0] a,
                       input logic [OP_W-1:0] b, input logic [W-1:0] c,
                       input string tag);
      logic [W-1:0] tot;
      @(negedge clk);
      tot = out_sum + out_carry;
      chk(out_valid === pv[2], "R2 out_valid", W'(out_valid), W'(pv[2]));
      if (pv[2]) begin
         chk(tot === pe[2], pt[2], tot, pe[2]);
         last_s  = out_sum;
         last_c  = out_carry;
         hold_ok = 1'b1;
      end else if (hold_ok) begin
         chk(out_sum === last_s && out_carry === last_c, "R6 hold", out_sum, last_s);
      end
      pv[2] = pv[1]; pe[2] = pe[1]; pc[2] = pc[1]; pt[2] = pt[1];
      pv[1] = pv[0]; pe[1] = pe[0]; pc[1] = pc[0]; pt[1] = pt[0];
      pv[0] = v;
      pe[0] = v ? (W'(a) * W'(b) + c) : '0;
      pc[0] = c;
      pt[0] = tag;
      in_valid = v;
      op_a     = a;
      op_b     = b;
      // addend for the operation issued two steps ago, junk otherwise (R4)
      addend   = pv[2] ? pc[2] : rnd_add();
   endtask

   task automatic drain();
      repeat (3) step(1'b0, rnd_op(), rnd_op(), rnd_add(), "-");
   endtask

   task automatic t_reset_state();
      rst = 1'b1;
      in_valid = 1'b1;
      repeat (3) @(negedge clk);
      chk(out_valid === 1'b0, "R5 out_valid in reset", W'(out_valid), '0);
      rst = 1'b0;
      in_valid = 1'b0;
      clear_model();
      repeat (3) step(1'b0, '0, '0, '0, "-");
   endtask

   task automatic t_zero();
      step(1'b1, '0, rnd_op(), rnd_add(), "R8 a=0");
      step(1'b1, rnd_op(), '0, rnd_add(), "R8 b=0");
      step(1'b1, '0, '0, rnd_add(), "R8 both=0");
      step(1'b1, '0, '0, '0, "R8 all zero");
      drain();
   endtask

   task automatic t_negative_digits();
      logic [OP_W-1:0] ones = '1;
      step(1'b1, ones, ones, '1, "R7 all ones wrap");
      step(1'b1, ones, ones, '0, "R7 all ones");
      step(1'b1, rnd_op(), OP_W'({27{2'b10}}), rnd_add(), "R7 digits -1/-2");
      step(1'b1, rnd_op(), OP_W'({18{3'b110}}), rnd_add(), "R7 digits mixed");
      step(1'b1, ones, OP_W'({27{2'b01}}), '1, "R7 positive digits");
      drain();
   endtask

   task automatic t_single_bits();
      for (int i = 0; i < OP_W; i++) begin
         step(1'b1, OP_W'(1) << i, OP_W'(1) << (OP_W - 1 - i), rnd_add(), "R9 single bits");
      end
      for (int i = 0; i < OP_W; i++) begin
         step(1'b1, rnd_op(), OP_W'(1) << i, '0, "R9 single multiplier bit");
      end
      drain();
   endtask

   task automatic t_stream();
      for (int i = 0; i < 300; i++) begin
         step(1'b1, rnd_op(), rnd_op(), rnd_add(), "R3 back-to-back");
      end
      drain();
   endtask

   task automatic t_addend_timing();
      logic [OP_W-1:0] a = rnd_op();
      logic [OP_W-1:0] b = rnd_op();
      for (int i = 0; i < 20; i++) begin
         step(1'b1, a, b, rnd_add(), "R4 addend per op");
      end
      drain();
   endtask

   task automatic t_bubbles();
      for (int i = 0; i < 60; i++) begin
         if (($urandom() % 3) == 0)
            step(1'b1, rnd_op(), rnd_op(), rnd_add(), "R1 with bubbles");
         else
            step(1'b0, rnd_op(), rnd_op(), rnd_add(), "-");
      end
      drain();
   endtask

   task automatic t_latency();
      drain();
      step(1'b1, rnd_op(), rnd_op(), rnd_add(), "R2 lone op");
      drain();
   endtask

   task automatic t_mid_reset();
      step(1'b1, rnd_op(), rnd_op(), rnd_add(), "R5 flushed");
      step(1'b1, rnd_op(), rnd_op(), rnd_add(), "R5 flushed");
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      in_valid = 1'b0;
      chk(out_valid === 1'b0, "R5 after reset", W'(out_valid), '0);
      clear_model();
      hold_ok = 1'b0;
      repeat (3) step(1'b0, rnd_op(), rnd_op(), rnd_add(), "-");
      step(1'b1, rnd_op(), rnd_op(), rnd_add(), "R5 first after reset");
      drain();
   endtask

   initial begin
      clear_model();
      t_reset_state();
      t_zero();
      t_negative_digits();
      t_single_bits();
      t_latency();
      t_addend_timing();
      t_bubbles();
      t_stream();
      t_mid_reset();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule